// File: doc/BRIEF.md
# Control Line Pulse Discriminator

This block watches two active-low control lines that a host drives into the module and sorts each low pulse by how long it lasted, measured in cycles of the 25 MHz local clock. A low pulse on the host reset line that lasts long enough (nominally 100 ms, or 2,500,000 clocks) becomes a single-cycle module reset request. A low pulse on the attention line that falls inside a window around 2 µs (nominally 50 clocks) becomes a single-cycle attention request. A pulse of the wrong length is dropped, and a one-cycle reject flag for that line is raised in its place.

Both lines are brought into the clock domain through two-flop synchronisers. A saturating counter measures each low interval, and a registered judge classifies the interval on the rising edge that ends it. The block also drives a busy line back to the host. Low on that line means busy and high means not busy. The line is a registered image of an internal busy signal, and it is held at busy while a qualifying reset pulse is still being held low by the host.

All pins are plain level or pulse signals. Nothing flows through the block as data, so no handshake or back-pressure applies.

Top module: `control_pulse_discriminator`

## Requirements
- R1: While `rst_ni` is low, `reset_req_o`, `attn_req_o`, `reset_rej_o` and `attn_rej_o` are 0 and `busy_line_no` is 0 (busy).
- R2: Each line passes through a two-flop synchroniser. A verdict for a pulse appears on the third rising clock edge after the line returns high, and it is visible for that cycle only.
- R3: An attention low pulse of L clocks with ATN_MIN_LEN <= L <= ATN_MAX_LEN (defaults 40 and 60) gives one `attn_req_o` pulse and no `attn_rej_o`. Both window limits are inclusive.
- R4: An attention low pulse shorter than ATN_MIN_LEN or longer than ATN_MAX_LEN, including a one-clock glitch, gives one `attn_rej_o` pulse and no `attn_req_o`.
- R5: A reset low pulse of at least RST_MIN_LEN clocks (default 2,000,000) gives one `reset_req_o` pulse when the line returns high, and no `reset_rej_o`.
- R6: A reset low pulse shorter than RST_MIN_LEN gives one `reset_rej_o` pulse and no `reset_req_o`.
- R7: Width counters saturate at their all-ones value and do not wrap. A very long attention pulse is therefore rejected, and a very long reset pulse is still accepted.
- R8: `busy_line_no` is the inverse of `busy_i`, registered once. It follows a change of `busy_i` one clock edge later.
- R9: While the synchronised reset line has been low for at least RST_MIN_LEN clocks and is still low, `busy_line_no` is 0 whatever `busy_i` is. The override ends within a few clocks after the line returns high.
- R10: Every event output is high for at most one cycle at a time, and accept and reject for the same line are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 25 MHz local clock |
| rst_ni | input | 1 | Asynchronous chip reset, active low |
| host_rst_line_ni | input | 1 | Host reset control line, active low, asynchronous |
| host_atn_line_ni | input | 1 | Host attention control line, active low, asynchronous |
| busy_i | input | 1 | Internal busy indication, high = busy |
| busy_line_no | output | 1 | Busy status line to host, low = busy |
| reset_req_o | output | 1 | One-cycle module reset request |
| attn_req_o | output | 1 | One-cycle attention request |
| reset_rej_o | output | 1 | One-cycle flag: reset-line pulse had the wrong length |
| attn_rej_o | output | 1 | One-cycle flag: attention-line pulse had the wrong length |

## Verification
A pulse verdict is due on the third rising edge after the line goes high again. That is two edges of synchronisation and one registered judgement. The driver task writes each expected verdict into the scoreboard stamped with that exact cycle, and the monitor compares the event outputs and the cycle count at every falling edge. A change of `busy_i` is due one edge later and is checked at the next falling edge. The reset-hold override is checked well inside the held low interval and again several edges after release, clear of the counter-clear and output-register latency.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

  // Verdict a judge reaches on the edge that ends a low interval.
  typedef enum logic [1:0] {
    VERDICT_NONE   = 2'd0,
    VERDICT_ACCEPT = 2'd1,
    VERDICT_REJECT = 2'd2
  } verdict_e;

  // Counter width able to hold limit+1 so the all-ones saturation value
  // always lies beyond the largest length that matters.
  function automatic int unsigned cnt_bits(input int unsigned limit);
    return $clog2(limit + 2);
  endfunction

endpackage

// File: rtl/cpd_sync.sv
module cpd_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  // Idle level of an active-low line is high, so both stages reset to 1.
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q;
    logic stable_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q   <= 1'b1;
        stable_q <= 1'b1;
      end else begin
        meta_q   <= async_i[b];
        stable_q <= meta_q;
      end
    end
    assign sync_o[b] = stable_q;
  end

endmodule

// File: rtl/cpd_width_meter.sv
module cpd_width_meter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lvl_i,
  output logic          rise_o,
  output logic [CW-1:0] len_o
);

  localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

  logic          lvl_q;
  logic [CW-1:0] cnt_q;

  // Counts sampled-low clocks; holds at the top value instead of wrapping.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_i;
      if (lvl_i) begin
        cnt_q <= '0;
      end else if (cnt_q != CNT_TOP) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign len_o  = cnt_q;

endmodule

// File: rtl/cpd_judge.sv
module cpd_judge
  import cpd_pkg::*;
#(
  parameter int unsigned CW      = 8,
  parameter int unsigned MIN_LEN = 1,
  parameter int unsigned MAX_LEN = 1,
  parameter bit          BOUNDED = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic [CW-1:0] len_i,
  output logic          accept_o,
  output logic          reject_o
);

  localparam logic [CW-1:0] LO = CW'(MIN_LEN);

  logic     fits;
  verdict_e verdict;

  if (BOUNDED) begin : g_window
    localparam logic [CW-1:0] HI = CW'(MAX_LEN);
    assign fits = (len_i >= LO) && (len_i <= HI);
  end else begin : g_floor
    assign fits = (len_i >= LO);
  end

  always_comb begin
    verdict = VERDICT_NONE;
    if (rise_i) begin
      verdict = fits ? VERDICT_ACCEPT : VERDICT_REJECT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      accept_o <= (verdict == VERDICT_ACCEPT);
      reject_o <= (verdict == VERDICT_REJECT);
    end
  end

endmodule

// File: rtl/cpd_busy_drive.sv
module cpd_busy_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic force_i,
  output logic busy_line_no
);

  // Line reports busy during chip reset and whenever forced.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_line_no <= 1'b0;
    end else begin
      busy_line_no <= ~(busy_i | force_i);
    end
  end

endmodule

// File: rtl/control_pulse_discriminator.sv
module control_pulse_discriminator
  import cpd_pkg::*;
#(
  parameter int unsigned ATN_MIN_LEN = 40,
  parameter int unsigned ATN_MAX_LEN = 60,
  parameter int unsigned RST_MIN_LEN = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_rst_line_ni,
  input  logic host_atn_line_ni,
  input  logic busy_i,
  output logic busy_line_no,
  output logic reset_req_o,
  output logic attn_req_o,
  output logic reset_rej_o,
  output logic attn_rej_o
);

  localparam int unsigned RST_CW = cnt_bits(RST_MIN_LEN);
  localparam int unsigned ATN_CW = cnt_bits(ATN_MAX_LEN);
  localparam logic [RST_CW-1:0] RST_HOLD = RST_CW'(RST_MIN_LEN);

  logic [1:0]        lines_sync;
  logic              rst_lvl, atn_lvl;
  logic              rst_rise, atn_rise;
  logic [RST_CW-1:0] rst_len;
  logic [ATN_CW-1:0] atn_len;
  logic              rst_hold;

  cpd_sync #(.W(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({host_rst_line_ni, host_atn_line_ni}),
    .sync_o  (lines_sync)
  );

  assign rst_lvl = lines_sync[1];
  assign atn_lvl = lines_sync[0];

  cpd_width_meter #(.CW(RST_CW)) u_rst_meter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (rst_lvl),
    .rise_o (rst_rise),
    .len_o  (rst_len)
  );

  cpd_width_meter #(.CW(ATN_CW)) u_atn_meter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (atn_lvl),
    .rise_o (atn_rise),
    .len_o  (atn_len)
  );

  cpd_judge #(
    .CW      (RST_CW),
    .MIN_LEN (RST_MIN_LEN),
    .MAX_LEN (RST_MIN_LEN),
    .BOUNDED (1'b0)
  ) u_rst_judge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rst_rise),
    .len_i    (rst_len),
    .accept_o (reset_req_o),
    .reject_o (reset_rej_o)
  );

  cpd_judge #(
    .CW      (ATN_CW),
    .MIN_LEN (ATN_MIN_LEN),
    .MAX_LEN (ATN_MAX_LEN),
    .BOUNDED (1'b1)
  ) u_atn_judge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (atn_rise),
    .len_i    (atn_len),
    .accept_o (attn_req_o),
    .reject_o (attn_rej_o)
  );

  // A reset pulse that has already qualified and is still low.
  assign rst_hold = ~rst_lvl & (rst_len >= RST_HOLD);

  cpd_busy_drive u_busy (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy_i),
    .force_i      (rst_hold),
    .busy_line_no (busy_line_no)
  );

endmodule

// File: rtl/cpd_checker.sv
module cpd_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic host_rst_line_ni,
  input logic host_atn_line_ni,
  input logic busy_i,
  input logic busy_line_no,
  input logic reset_req_o,
  input logic attn_req_o,
  input logic reset_rej_o,
  input logic attn_rej_o
);

  p_single_rst_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> !reset_req_o);
  p_single_atn_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attn_req_o |=> !attn_req_o);
  p_single_rst_rej_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_rej_o |=> !reset_rej_o);
  p_single_atn_rej_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attn_rej_o |=> !attn_rej_o);

  p_atn_exclusive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(attn_req_o && attn_rej_o));
  p_rst_exclusive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reset_req_o && reset_rej_o));

  p_atn_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attn_req_o |-> ($past(host_atn_line_ni, 3) && !$past(host_atn_line_ni, 4)));
  p_rst_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> ($past(host_rst_line_ni, 3) && !$past(host_rst_line_ni, 4)));

  p_busy_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !busy_line_no);

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !(reset_req_o || attn_req_o || reset_rej_o || attn_rej_o || busy_line_no));

endmodule

bind control_pulse_discriminator cpd_checker u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .host_rst_line_ni (host_rst_line_ni),
  .host_atn_line_ni (host_atn_line_ni),
  .busy_i           (busy_i),
  .busy_line_no     (busy_line_no),
  .reset_req_o      (reset_req_o),
  .attn_req_o       (attn_req_o),
  .reset_rej_o      (reset_rej_o),
  .attn_rej_o       (attn_rej_o)
);

// File: tb/sim_control_pulse_discriminator.sv
module sim_control_pulse_discriminator;

  localparam int unsigned T_ATN_MIN = 40;
  localparam int unsigned T_ATN_MAX = 60;
  localparam int unsigned T_RST_MIN = 200;

  // Event kinds double as bit index in the monitored vector.
  localparam int K_ATN_ACC = 0;
  localparam int K_ATN_REJ = 1;
  localparam int K_RST_ACC = 2;
  localparam int K_RST_REJ = 3;

  typedef struct {
    int    kind;
    int    due;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_line = 1'b1;
  logic atn_line = 1'b1;
  logic busy_in = 1'b0;
  logic busy_line_n, rst_req, atn_req, rst_rej, atn_rej;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];
  exp_t mon_item;
  logic [3:0] mon_ev;
  logic [3:0] mon_want;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  control_pulse_discriminator #(
    .ATN_MIN_LEN (T_ATN_MIN),
    .ATN_MAX_LEN (T_ATN_MAX),
    .RST_MIN_LEN (T_RST_MIN)
  ) u0 (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .host_rst_line_ni (rst_line),
    .host_atn_line_ni (atn_line),
    .busy_i           (busy_in),
    .busy_line_no     (busy_line_n),
    .reset_req_o      (rst_req),
    .attn_req_o       (atn_req),
    .reset_rej_o      (rst_rej),
    .attn_rej_o       (atn_rej)
  );

  task automatic check(input string tag, input int actual, input int expected, input string what);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, actual, expected);
    end
  endtask

  // Driver: hold a line low for n clocks, then log the verdict due on the
  // third rising edge after release (two sync stages, one judge register).
  task automatic pulse(input bit on_rst, input int n, input int kind, input string tag);
    if (on_rst) rst_line = 1'b0; else atn_line = 1'b0;
    repeat (n) @(negedge clk);
    if (on_rst) rst_line = 1'b1; else atn_line = 1'b1;
    exp_q.push_back('{kind, cyc + 3, tag});
    repeat (12) @(negedge clk);
  endtask

  // Monitor: every observed event pops one expected item.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      mon_ev = {rst_rej, rst_req, atn_rej, atn_req};
      if (mon_ev != 4'b0000) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected event actual %b at cycle %0d expected none", mon_ev, cyc);
        end else begin
          mon_item = exp_q.pop_front();
          mon_want = 4'b0001 << mon_item.kind;
          if (mon_ev != mon_want || cyc != mon_item.due) begin
            errors++;
            $display("FAIL %s event actual %b at cycle %0d expected %b at cycle %0d",
                     mon_item.tag, mon_ev, cyc, mon_want, mon_item.due);
          end
        end
      end
    end
  end

  initial begin
    repeat (200_000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet outputs and busy line low during reset
    check("R1", int'({rst_req, atn_req, rst_rej, atn_rej}), 0, "events in reset");
    check("R1", int'(busy_line_n), 0, "busy line in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", int'(busy_line_n), 1, "idle busy line");

    // R8: registered inverse of busy_i, one edge later
    busy_in = 1'b1;
    @(negedge clk);
    check("R8", int'(busy_line_n), 0, "busy asserted");
    busy_in = 1'b0;
    @(negedge clk);
    check("R8", int'(busy_line_n), 1, "busy released");
    repeat (4) @(negedge clk);

    // Attention window, inclusive limits
    pulse(1'b0, 50, K_ATN_ACC, "R3 nominal");
    pulse(1'b0, T_ATN_MIN, K_ATN_ACC, "R3 lower edge");
    pulse(1'b0, T_ATN_MAX, K_ATN_ACC, "R3 upper edge");
    pulse(1'b0, T_ATN_MIN - 1, K_ATN_REJ, "R4 short");
    pulse(1'b0, T_ATN_MAX + 1, K_ATN_REJ, "R4 long");
    pulse(1'b0, 1, K_ATN_REJ, "R4 glitch");
    pulse(1'b0, 300, K_ATN_REJ, "R7 atn saturate");

    // Reset threshold
    pulse(1'b1, T_RST_MIN - 1, K_RST_REJ, "R6 short");
    pulse(1'b1, T_RST_MIN, K_RST_ACC, "R5 threshold");
    pulse(1'b1, 1, K_RST_REJ, "R6 glitch");

    // R7 and R9: long reset pulse saturates, busy forced while held
    rst_line = 1'b0;
    repeat (260) @(negedge clk);
    check("R9", int'(busy_line_n), 0, "busy forced while reset held");
    repeat (40) @(negedge clk);
    rst_line = 1'b1;
    exp_q.push_back('{K_RST_ACC, cyc + 3, "R7 rst saturate"});
    repeat (12) @(negedge clk);
    check("R9", int'(busy_line_n), 1, "busy released after reset pulse");

    repeat (10) @(negedge clk);
    check("R2", exp_q.size(), 0, "verdicts still outstanding");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule